// File: doc/BRIEF.md
# Two-Key Register Unlock Guard

This block shields a control register behind a lock bit. The lock bit clears only when software writes two fixed key words, in order, to a key port. While the lock is set, writes to the control register and to a companion interrupt-enable register have no effect. Any wrong key, or any key write made while the register is already open, sends the guard into a lockout state. Only reset leaves that state. During lockout, accesses to the key port and to the control register answer with a bus error.

The guard sits on a simple single-cycle register bus. Write data is committed at the clock edge. Read data and the error flag are combinational from the current address and state.

The bus has three word addresses:
- Address 0 is the key port. It always reads as zero.
- Address 1 is the control register. Its bit 0 is the lock bit.
- Address 2 is the interrupt-enable register.

The key pair is a parameter. One instance can guard the main control register with one pair, and a second instance can guard an options register with a different pair.

The sequence tracker has four states:
- IDLE: locked, waiting for the first key.
- HALF: the first key has been accepted.
- OPEN: unlocked.
- BARRED: permanent lockout.

Its transitions are:
- From IDLE, the first key goes to HALF, and any other key word goes to BARRED.
- From HALF, the second key goes to OPEN, and any other key word goes to BARRED.
- From OPEN, any key write goes to BARRED. A control write with bit 0 set goes back to IDLE (relock).
- BARRED stays in BARRED until reset.

Top module: `key_unlock_guard`

## Requirements
- R1: After reset the lock bit (control bit 0) reads 1, the other control bits read 0, the interrupt-enable register reads 0 and no bus error is signalled.
- R2: Writing KEY_FIRST and then KEY_SECOND to address 0 clears the lock bit; it reads 0 from the cycle after the second key write.
- R3: Reads and writes to other addresses between the two key writes do not break the sequence; only key-port writes advance it.
- R4: A first key write that is not KEY_FIRST, or a second key write that is not KEY_SECOND, enters lockout; the lock bit stays 1.
- R5: Any key-port write while unlocked enters lockout and sets the lock bit.
- R6: In lockout, every read or write to address 0 or 1 raises bus_err in the same cycle, lockout persists over any bus traffic and a correct key pair, and only reset leaves it.
- R7: Reads of address 0 always return zero.
- R8: While the lock bit is 1, writes to address 1 and address 2 leave both registers unchanged.
- R9: While unlocked, writes to address 1 update bits DATA_W-1:1, and writes to address 2 update the interrupt-enable register. A write to address 1 with bit 0 set relocks, updates the other bits in the same write and returns the tracker to IDLE, so a fresh key pair unlocks again.
- R10: bus_err is raised only in lockout and only for addresses 0 and 1; addresses other than 0, 1 and 2 read zero.
- R11: The key pair is a parameter; an instance built with 0x08192A3B then 0x4C5D6E7F unlocks with that pair and enters lockout on the default pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| bus_err | output | 1 | Error response (combinational) |
| lock_o | output | 1 | Current lock bit |

## Verification
The bench targets four corner cases:
- A key pair split by other bus traffic. A tracker that counted every access would reject it.
- A repeated pair while already unlocked. A guard that re-accepted it would never enter lockout.
- A relock write carrying new control bits. A design that dropped that write, or that entered lockout on it, would show stale bits or an error.
- Lockout followed by the correct keys. A design that let lockout decay would unlock again.

A second instance with the options key pair runs on the same bus. This catches any key value hard-wired into the tracker.

// File: rtl/kug_pkg.sv
package kug_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2,
        ST_BARRED = 2'd3
    } kug_state_e;

    localparam int unsigned KUG_ADDR_KEY  = 0;
    localparam int unsigned KUG_ADDR_CTRL = 1;
    localparam int unsigned KUG_ADDR_IEN  = 2;
endpackage

// File: rtl/kug_seq_fsm.sv
module kug_seq_fsm
    import kug_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              relock,
    output kug_state_e        state_o,
    output logic              locked_o,
    output logic              barred_o
);
    kug_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (key_wr) st_d = (key_data == KEY_FIRST)  ? ST_HALF : ST_BARRED;
            ST_HALF: if (key_wr) st_d = (key_data == KEY_SECOND) ? ST_OPEN : ST_BARRED;
            ST_OPEN: begin
                if (key_wr)      st_d = ST_BARRED;
                else if (relock) st_d = ST_IDLE;
            end
            ST_BARRED: st_d = ST_BARRED;
            default:   st_d = ST_BARRED;
        endcase
    end

    always_comb begin
        locked_o = 1'b1;
        barred_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_HALF: locked_o = 1'b1;
            ST_OPEN:          locked_o = 1'b0;
            ST_BARRED:        barred_o = 1'b1;
            default:          barred_o = 1'b1;
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/kug_regs.sv
module kug_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ien_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:1] ctrl_bits_o,
    output logic [DATA_W-1:0] ien_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_bits_o <= '0;
            ien_o       <= '0;
        end else begin
            if (ctrl_we) ctrl_bits_o <= wdata[DATA_W-1:1];
            if (ien_we)  ien_o       <= wdata;
        end
    end
endmodule

// File: rtl/kug_bus_resp.sv
module kug_bus_resp
    import kug_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              locked,
    input  logic              barred,
    input  logic [DATA_W-1:1] ctrl_bits,
    input  logic [DATA_W-1:0] ien,
    output logic              key_hit,
    output logic              ctrl_hit,
    output logic              ien_hit,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    assign key_hit  = (bus_addr == ADDR_W'(KUG_ADDR_KEY));
    assign ctrl_hit = (bus_addr == ADDR_W'(KUG_ADDR_CTRL));
    assign ien_hit  = (bus_addr == ADDR_W'(KUG_ADDR_IEN));

    always_comb begin
        if (ctrl_hit)     rdata = {ctrl_bits, locked};
        else if (ien_hit) rdata = ien;
        else              rdata = '0;
    end

    assign err = barred && (bus_wr || bus_rd) && (key_hit || ctrl_hit);
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
    import kug_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              lock_o
);
    kug_state_e        st;
    logic              locked, barred;
    logic              key_hit, ctrl_hit, ien_hit;
    logic [DATA_W-1:1] ctrl_bits;
    logic [DATA_W-1:0] ien;
    logic              key_wr, ctrl_we, ien_we, relock;

    assign key_wr  = bus_wr && key_hit && !barred;
    assign ctrl_we = bus_wr && ctrl_hit && !locked;
    assign ien_we  = bus_wr && ien_hit && !locked;
    assign relock  = ctrl_we && bus_wdata[0];

    kug_seq_fsm #(.DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_fsm (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata),
        .relock(relock), .state_o(st), .locked_o(locked), .barred_o(barred)
    );

    kug_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ien_we(ien_we),
        .wdata(bus_wdata), .ctrl_bits_o(ctrl_bits), .ien_o(ien)
    );

    kug_bus_resp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_resp (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .locked(locked), .barred(barred), .ctrl_bits(ctrl_bits), .ien(ien),
        .key_hit(key_hit), .ctrl_hit(ctrl_hit), .ien_hit(ien_hit),
        .rdata(bus_rdata), .err(bus_err)
    );

    assign lock_o = locked;
endmodule

// File: rtl/kug_checker.sv
module kug_checker
    import kug_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              lock_o,
    input kug_state_e        state,
    input logic [DATA_W-1:1] ctrl_bits
);
    // R6
    barred_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BARRED |=> state == ST_BARRED);

    // R7
    key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(KUG_ADDR_KEY)) |-> bus_rdata == '0);

    // R2
    unlock_needs_key2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(bus_wr && bus_addr == ADDR_W'(KUG_ADDR_KEY) && bus_wdata == KEY_SECOND));

    // R8
    locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && bus_wr && bus_addr == ADDR_W'(KUG_ADDR_CTRL)) |=> $stable(ctrl_bits));

    // R6
    barred_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BARRED && (bus_wr || bus_rd) &&
         (bus_addr == ADDR_W'(KUG_ADDR_KEY) || bus_addr == ADDR_W'(KUG_ADDR_CTRL))) |-> bus_err);

    // R10
    err_only_barred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (state == ST_BARRED && lock_o));
endmodule

bind key_unlock_guard kug_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .lock_o(lock_o), .state(st), .ctrl_bits(ctrl_bits)
);

// File: tb/tb_key_unlock_guard.sv
module tb_key_unlock_guard;
    localparam logic [31:0] K1  = 32'h4567_0123;
    localparam logic [31:0] K2  = 32'hCDEF_89AB;
    localparam logic [31:0] OK1 = 32'h0819_2A3B;
    localparam logic [31:0] OK2 = 32'h4C5D_6E7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata [2];
    logic        err [2];
    logic        lock [2];

    always #10 clk = ~clk;

    key_unlock_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .bus_err(err[0]), .lock_o(lock[0])
    );
    key_unlock_guard #(.KEY_FIRST(OK1), .KEY_SECOND(OK2)) dut_opt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .bus_err(err[1]), .lock_o(lock[1])
    );

    int errors = 0, checks = 0;
    // model state: 0 idle, 1 half, 2 open, 3 barred
    int          mst [2];
    logic [31:0] mctrl [2];
    logic [31:0] mien [2];

    function automatic logic [31:0] kfirst(int i);  return (i == 0) ? K1 : OK1; endfunction
    function automatic logic [31:0] ksecond(int i); return (i == 0) ? K2 : OK2; endfunction

    function automatic logic [31:0] exp_rdata(int i, logic [3:0] a);
        if (a == 4'd1) return {mctrl[i][31:1], (mst[i] != 2)};
        if (a == 4'd2) return mien[i];
        return 32'h0;
    endfunction

    function automatic logic exp_err(int i, logic [3:0] a);
        return (mst[i] == 3) && (a == 4'd0 || a == 4'd1);
    endfunction

    function automatic int next_key_state(int st, logic [32:0] d_i, int i);
        logic [31:0] d = d_i[31:0];
        case (st)
            0:       return (d == kfirst(i)) ? 1 : 3;
            1:       return (d == ksecond(i)) ? 2 : 3;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            mst[i] = 0; mctrl[i] = '0; mien[i] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rst_n = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_read(input logic [3:0] a, input string tag);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        #1;
        for (int i = 0; i < 2; i++) begin
            chk(rdata[i] == exp_rdata(i, a), tag, rdata[i], exp_rdata(i, a));
            chk(err[i] == exp_err(i, a), tag, 32'(err[i]), 32'(exp_err(i, a)));
        end
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        #1;
        for (int i = 0; i < 2; i++)
            chk(err[i] == exp_err(i, a), tag, 32'(err[i]), 32'(exp_err(i, a)));
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            if (a == 4'd0 && mst[i] != 3) mst[i] = next_key_state(mst[i], {1'b0, d}, i);
            else if (a == 4'd1 && mst[i] == 2) begin
                mctrl[i] = d & 32'hFFFF_FFFE;
                if (d[0]) mst[i] = 0;
            end else if (a == 4'd2 && mst[i] == 2) mien[i] = d;
        end
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic chk_lock(input int i, input logic exp, input string tag);
        #1;
        chk(lock[i] == exp, tag, 32'(lock[i]), 32'(exp));
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        do_reset();
        // R1 reset state
        do_read(4'd1, "R1");
        do_read(4'd2, "R1");
        chk_lock(0, 1'b1, "R1");
        // R8 locked writes ignored
        do_write(4'd1, 32'h0000_00F0, "R8");
        do_write(4'd2, 32'h0000_FFFF, "R8");
        do_read(4'd1, "R8");
        do_read(4'd2, "R8");
        // R2/R3 sequence with interleaved traffic; opt instance goes barred (R11)
        do_write(4'd0, K1, "R2");
        do_read(4'd1, "R3");
        do_write(4'd2, 32'h1, "R3");
        do_write(4'd0, K2, "R2");
        chk_lock(0, 1'b0, "R2");
        chk_lock(1, 1'b1, "R11");
        do_read(4'd1, "R2");
        // R7
        do_read(4'd0, "R7");
        do_read(4'd5, "R10");
        // R9 updates while open, relock with data
        do_write(4'd1, 32'h0000_A5A4, "R9");
        do_write(4'd2, 32'h0000_0055, "R9");
        do_read(4'd1, "R9");
        do_read(4'd2, "R9");
        do_write(4'd1, 32'h0000_1231, "R9");
        do_read(4'd1, "R9");
        do_write(4'd0, K1, "R9");
        do_write(4'd0, K2, "R9");
        chk_lock(0, 1'b0, "R9");
        // R5 repeated key while open
        do_write(4'd0, K1, "R5");
        chk_lock(0, 1'b1, "R5");
        // R6 lockout
        do_read(4'd0, "R6");
        do_read(4'd1, "R6");
        do_write(4'd1, 32'h0, "R6");
        do_write(4'd0, K1, "R6");
        do_write(4'd0, K2, "R6");
        chk_lock(0, 1'b1, "R6");
        do_read(4'd2, "R10");
        do_reset();
        do_read(4'd1, "R6");
        // R4 bad first key, then bad second key
        do_write(4'd0, 32'h1234_5678, "R4");
        do_read(4'd1, "R4");
        do_reset();
        do_write(4'd0, K1, "R4");
        do_write(4'd0, K1, "R4");
        do_read(4'd0, "R4");
        chk_lock(0, 1'b1, "R4");
        // R11 options pair on the second instance
        do_reset();
        do_write(4'd0, OK1, "R11");
        do_write(4'd0, OK2, "R11");
        chk_lock(1, 1'b0, "R11");
        do_read(4'd1, "R11");
        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  a;
            logic [31:0] d;
            int          pick;
            pick = int'($urandom_range(0, 5));
            case (pick)
                0: d = K1; 1: d = K2; 2: d = OK1; 3: d = OK2;
                default: d = $urandom;
            endcase
            a = 4'($urandom_range(0, 3));
            if (mst[0] == 3 && mst[1] == 3 && $urandom_range(0, 7) == 0) do_reset();
            else if ($urandom_range(0, 1) == 1) do_read(a, "R10");
            else do_write(a, d, "R9");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule